// File: doc/BRIEF.md
# Output Offset Trim Calibration Sequencer

This block drives the digital output-offset trim of a two-channel tape playback front end. The device under control holds one signed offset code per channel and reports through a one-bit sign monitor whether its current offset sits above or below zero. On a start request the sequencer turns the monitor on for the chosen channel. It then writes trial codes one step at a time, waiting a settling interval before each look at the monitor, until the sign reverses. The code reached at that point is kept as the result for that channel and the current head.

Results are kept for all four combinations of channel and head. The device holds only one code per channel, so when the head input changes the sequencer reloads both channel codes for the new head. Calibration is allowed only while the tape drive is stopped or while the power-on reset condition is present. All device writes go through a simple request/acknowledge write port that stands in for the serial bus.

Top module: `trim_cal_seq`

## Requirements
- R1: After reset, wr_req, done, err and refused are 0. All four stored results are code 0, and the block treats both device codes as 0.
- R2: A write is one edge where wr_req and wr_ack are both high. While wr_req is high and wr_ack is low, wr_req, wr_kind and wr_data keep their values. wr_kind is 0 for a control write, 1 for the channel A code and 2 for the channel B code. Codes are 6-bit two's complement in wr_data.
- R3: A start seen in idle while drive_busy is 0, or while por_active is 1, begins a run. The first write is a control write with wr_data bit 1 (monitor enable) set to 1 and bit 0 equal to chan_sel (0 = A, 1 = B).
- R4: A start seen in idle while drive_busy is 1 and por_active is 0 produces no write. Instead refused pulses for one cycle, in the cycle after that edge.
- R5: The first trial code of a run is the last code written to that channel, or 0 if none has been written.
- R6: After each trial code is accepted, mon_in is sampled exactly SETTLE_CYC rising edges later, and no write is issued meanwhile.
- R7: A low sample makes the next trial code one below the current code. A high sample makes it one above.
- R8: When a sample differs from the previous sample of the same run, the current code is stored for (channel, head). A control write follows with bit 1 = 0 and bit 0 = channel. done then pulses for one cycle after that write is accepted, with err = 0.
- R9: If a step would go past 31 or below -32, no further code is written. The disable control write follows, done pulses with err = 1, and the stored result is left unchanged.
- R10: In idle, a head_sel value that differs from the current head makes the block write the stored channel A code for the new head (kind 1), then the stored channel B code (kind 2).
- R11: A head_sel change during a run waits until the run ends. The run's result is stored under the head that was current when the run started.
- R12: A start that arrives while a run or reload is in progress is ignored: it causes no refusal and no extra write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Calibration request |
| chan_sel | input | 1 | Channel to calibrate, 0 = A, 1 = B |
| head_sel | input | 1 | Currently active playback head |
| drive_busy | input | 1 | Tape drive is running |
| por_active | input | 1 | Power-on reset condition present |
| mon_in | input | 1 | Offset sign monitor from the device |
| wr_req | output | 1 | Write request |
| wr_kind | output | 2 | Write target: 0 control, 1 code A, 2 code B |
| wr_data | output | CODE_W | Write payload |
| wr_ack | input | 1 | Write accepted at this edge |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Last run ended at the code range limit |
| refused | output | 1 | One-cycle pulse for a start that was not allowed |

## Verification
done and refused are registered, so each is due in the cycle right after the edge that causes it: the accepted disable write for done, and the start edge for refused. The bench predicts both cycle by cycle and compares them on every clock. The monitor sample is due exactly SETTLE_CYC edges after a trial code is accepted. The bench models the device monitor so that it reports the wrong sign until one cycle before that edge. A sample taken even one edge early therefore changes the written code sequence, which the bench compares write by write against a queue built from the stepping rules.

// File: rtl/trim_pkg.sv
`timescale 1ns/1ps
package trim_pkg;
  typedef enum logic [1:0] {
    WK_CTRL = 2'd0,
    WK_OFFA = 2'd1,
    WK_OFFB = 2'd2
  } wr_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_EN, S_CODE, S_WAIT, S_DIS, S_HA, S_HB
  } cal_state_e;
endpackage

// File: rtl/trim_settle_timer.sv
`timescale 1ns/1ps
module trim_settle_timer #(
  parameter int SETTLE_CYC = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expire
);
  localparam int TW = $clog2(SETTLE_CYC + 1);

  logic [TW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (load) begin
      run <= 1'b1;
      cnt <= TW'(SETTLE_CYC - 1);
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign expire = run && (cnt == '0);

  // R6: each settle window ends in a single sampling cycle
  a_r6_single_expire: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);
endmodule

// File: rtl/trim_code_store.sv
`timescale 1ns/1ps
module trim_code_store #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        waddr,
  input  logic [CODE_W-1:0] wdata,
  input  logic              rhead,
  output logic [CODE_W-1:0] rd_a,
  output logic [CODE_W-1:0] rd_b
);
  localparam int DEPTH = 4;

  logic [CODE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rd_a = mem[{1'b0, rhead}];
  assign rd_b = mem[{1'b1, rhead}];
endmodule

// File: rtl/trim_wr_port.sv
`timescale 1ns/1ps
module trim_wr_port
  import trim_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  wr_kind_e          iss_kind,
  input  logic [CODE_W-1:0] iss_data,
  input  logic              wr_ack,
  output logic              wr_req,
  output logic [1:0]        wr_kind,
  output logic [CODE_W-1:0] wr_data,
  output logic              accept
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_req  <= 1'b0;
      wr_kind <= 2'd0;
      wr_data <= '0;
    end else if (issue) begin
      wr_req  <= 1'b1;
      wr_kind <= iss_kind;
      wr_data <= iss_data;
    end else if (wr_req && wr_ack) begin
      wr_req <= 1'b0;
    end
  end

  assign accept = wr_req && wr_ack;

  a_r2_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_kind) && $stable(wr_data)));
endmodule

// File: rtl/trim_cal_seq.sv
`timescale 1ns/1ps
module trim_cal_seq
  import trim_pkg::*;
#(
  parameter int CODE_W     = 6,
  parameter int SETTLE_CYC = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              chan_sel,
  input  logic              head_sel,
  input  logic              drive_busy,
  input  logic              por_active,
  input  logic              mon_in,
  output logic              wr_req,
  output logic [1:0]        wr_kind,
  output logic [CODE_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              done,
  output logic              err,
  output logic              refused
);
  localparam logic signed [CODE_W-1:0] CODE_MAX = {1'b0, {(CODE_W-1){1'b1}}};
  localparam logic signed [CODE_W-1:0] CODE_MIN = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic signed [CODE_W-1:0] ONE      = CODE_W'(1);

  cal_state_e st, st_n;
  logic ch_q, head_q, first_q, prev_q;
  logic signed [CODE_W-1:0] code_q, dev_a, dev_b, step_code;
  logic done_q, err_q, ref_q;

  logic accept, tmr_exp, tmr_load, st_we, iss, rhead;
  wr_kind_e iss_kind;
  logic [CODE_W-1:0] iss_data, rd_a, rd_b;
  logic head_chg, start_ok, flip, at_lim;

  function automatic logic [CODE_W-1:0] ctrl_word(input logic en, input logic ch);
    return {{(CODE_W-2){1'b0}}, en, ch};
  endfunction

  assign head_chg  = (head_sel != head_q);
  assign start_ok  = !drive_busy || por_active;
  assign flip      = !first_q && (mon_in != prev_q);
  assign at_lim    = mon_in ? (code_q == CODE_MAX) : (code_q == CODE_MIN);
  assign step_code = mon_in ? (code_q + ONE) : (code_q - ONE);
  assign rhead     = (st == S_IDLE) ? head_sel : head_q;

  always_comb begin
    st_n     = st;
    iss      = 1'b0;
    iss_kind = WK_CTRL;
    iss_data = '0;
    tmr_load = 1'b0;
    st_we    = 1'b0;
    case (st)
      S_IDLE: begin
        if (head_chg) begin
          iss = 1'b1; iss_kind = WK_OFFA; iss_data = rd_a; st_n = S_HA;
        end else if (start && start_ok) begin
          iss = 1'b1; iss_data = ctrl_word(1'b1, chan_sel); st_n = S_EN;
        end
      end
      S_EN: if (accept) begin
        iss = 1'b1; iss_kind = ch_q ? WK_OFFB : WK_OFFA; iss_data = code_q; st_n = S_CODE;
      end
      S_CODE: if (accept) begin
        tmr_load = 1'b1; st_n = S_WAIT;
      end
      S_WAIT: if (tmr_exp) begin
        if (flip || at_lim) begin
          st_we = flip;
          iss = 1'b1; iss_data = ctrl_word(1'b0, ch_q); st_n = S_DIS;
        end else begin
          iss = 1'b1; iss_kind = ch_q ? WK_OFFB : WK_OFFA; iss_data = step_code; st_n = S_CODE;
        end
      end
      S_DIS: if (accept) st_n = S_IDLE;
      S_HA: if (accept) begin
        iss = 1'b1; iss_kind = WK_OFFB; iss_data = rd_b; st_n = S_HB;
      end
      S_HB: if (accept) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      ch_q    <= 1'b0;
      head_q  <= 1'b0;
      first_q <= 1'b1;
      prev_q  <= 1'b0;
      code_q  <= '0;
      dev_a   <= '0;
      dev_b   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      ref_q   <= 1'b0;
    end else begin
      st     <= st_n;
      done_q <= 1'b0;
      ref_q  <= 1'b0;
      if (st == S_IDLE && head_chg) head_q <= head_sel;
      if (st == S_IDLE && !head_chg && start) begin
        if (start_ok) begin
          ch_q    <= chan_sel;
          code_q  <= chan_sel ? dev_b : dev_a;
          first_q <= 1'b1;
          err_q   <= 1'b0;
        end else begin
          ref_q <= 1'b1;
        end
      end
      if (st == S_WAIT && tmr_exp && !flip) begin
        if (at_lim) begin
          err_q <= 1'b1;
        end else begin
          code_q  <= step_code;
          prev_q  <= mon_in;
          first_q <= 1'b0;
        end
      end
      if (st == S_DIS && accept) done_q <= 1'b1;
      if (accept && wr_kind == WK_OFFA) dev_a <= wr_data;
      if (accept && wr_kind == WK_OFFB) dev_b <= wr_data;
    end
  end

  assign done    = done_q;
  assign err     = err_q;
  assign refused = ref_q;

  trim_wr_port #(.CODE_W(CODE_W)) u_port (
    .clk(clk), .rst(rst), .issue(iss), .iss_kind(iss_kind), .iss_data(iss_data),
    .wr_ack(wr_ack), .wr_req(wr_req), .wr_kind(wr_kind), .wr_data(wr_data), .accept(accept)
  );

  trim_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .expire(tmr_exp)
  );

  trim_code_store #(.CODE_W(CODE_W)) u_store (
    .clk(clk), .rst(rst), .we(st_we), .waddr({ch_q, head_q}), .wdata(code_q),
    .rhead(rhead), .rd_a(rd_a), .rd_b(rd_b)
  );

  a_r4_refuse_cause: assert property (@(posedge clk) disable iff (rst)
    refused |-> ($past(start) && $past(drive_busy) && !$past(por_active)));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_quiet_settle: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT) |-> !wr_req);

  a_r11_head_hold: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE) |=> $stable(head_q));

  a_r9_err_at_limit: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (code_q == CODE_MAX || code_q == CODE_MIN));
endmodule

// File: tb/sim_trim_cal_seq.sv
`timescale 1ns/1ps
module sim_trim_cal_seq;
  localparam int CW = 6;
  localparam int ST = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 1'b0, chan_sel = 1'b0, head_sel = 1'b0;
  logic drive_busy = 1'b0, por_active = 1'b0, mon_in = 1'b0, wr_ack = 1'b0;
  logic wr_req, done, err, refused;
  logic [1:0] wr_kind;
  logic [CW-1:0] wr_data;

  always #5 clk = ~clk;

  trim_cal_seq #(.CODE_W(CW), .SETTLE_CYC(ST)) u0 (
    .clk(clk), .rst(rst), .start(start), .chan_sel(chan_sel), .head_sel(head_sel),
    .drive_busy(drive_busy), .por_active(por_active), .mon_in(mon_in),
    .wr_req(wr_req), .wr_kind(wr_kind), .wr_data(wr_data), .wr_ack(wr_ack),
    .done(done), .err(err), .refused(refused)
  );

  int n_cmp = 0, n_bad = 0;
  int q_kind[$], q_data[$];
  bit q_final[$], q_err[$];
  string q_tag[$];
  int stored[2][2];
  int mdl_dev[2];
  int dev[2];
  int thr = 0, cal_ch = 0, since = 1000, ack_lat = 0, ack_cnt = 0, cur_head = 0;
  bit last_acc = 0, finished = 0;
  bit s_req, s_ack, s_start, s_busy, s_por, s_rst, s_qempty;
  logic [1:0] s_kind;
  logic [CW-1:0] s_data;

  function automatic int sx(input logic [CW-1:0] v);
    int r;
    r = int'(v);
    if (v[CW-1]) r = r - (1 << CW);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic push(input int k, input int d, input bit f, input bit e, input string t);
    q_kind.push_back(k); q_data.push_back(d); q_final.push_back(f);
    q_err.push_back(e); q_tag.push_back(t);
  endtask

  // stepping rules applied to an ideal sign monitor (high while code < th)
  task automatic plan_cal(input int ch, input int head, input int th);
    int code; bit first; bit prev; bit hi; string tag;
    code = mdl_dev[ch]; first = 1; prev = 0; tag = "R5";
    push(0, 2 + ch, 0, 0, "R3");
    forever begin
      push(ch ? 2 : 1, code, 0, 0, tag);
      mdl_dev[ch] = code;
      hi = (code < th);
      if (!first && hi != prev) begin
        stored[ch][head] = code;
        push(0, ch, 1, 0, "R8");
        break;
      end
      if ((hi && code == 31) || (!hi && code == -32)) begin
        push(0, ch, 1, 1, "R9");
        break;
      end
      code = hi ? code + 1 : code - 1;
      prev = hi; first = 0; tag = "R6 R7";
    end
  endtask

  task automatic plan_head(input int h, input string tag);
    push(1, stored[0][h], 0, 0, tag);
    push(2, stored[1][h], 0, 0, tag);
    mdl_dev[0] = stored[0][h];
    mdl_dev[1] = stored[1][h];
  endtask

  task automatic drain();
    wait (q_kind.size() == 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_start(input int ch);
    @(negedge clk);
    chan_sel = ch[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_cal(input int ch, input int th, input int lat);
    ack_lat = lat; thr = th; cal_ch = ch;
    plan_cal(ch, cur_head, th);
    pulse_start(ch);
    drain();
  endtask

  task automatic set_head(input int h, input string tag);
    plan_head(h, tag);
    @(negedge clk);
    head_sel = h[0];
    cur_head = h;
    drain();
  endtask

  // snapshot of the values present just before the next rising edge
  always begin
    @(negedge clk);
    #2;
    s_req = wr_req; s_ack = wr_ack; s_kind = wr_kind; s_data = wr_data;
    s_start = start; s_busy = drive_busy; s_por = por_active; s_rst = rst;
    s_qempty = (q_kind.size() == 0);
  end

  // device model: write acknowledge and sign monitor
  always @(negedge clk) begin
    bit hi;
    hi = (dev[cal_ch] < thr);
    mon_in = (since >= ST - 1) ? hi : !hi;
    if (last_acc) ack_cnt = 0;
    if (wr_req) begin
      wr_ack = (ack_cnt >= ack_lat);
      ack_cnt++;
    end else begin
      wr_ack = 1'b0;
      ack_cnt = 0;
    end
  end

  // per-clock comparison against the reference model
  always @(posedge clk) begin
    bit acc, exp_done, exp_err, exp_ref;
    int k, d;
    bit f, e;
    string t;
    #3;
    if (s_rst || rst) begin
      last_acc = 0;
    end else begin
      exp_done = 0; exp_err = 0;
      acc = s_req && s_ack;
      if (acc) begin
        if (q_kind.size() == 0) begin
          check(0, "R2 R4 R12", "unexpected write kind", int'(s_kind), -1);
        end else begin
          k = q_kind.pop_front(); d = q_data.pop_front(); f = q_final.pop_front();
          e = q_err.pop_front(); t = q_tag.pop_front();
          check(int'(s_kind) == k, t, "write kind", int'(s_kind), k);
          check(sx(s_data) == d, t, "write data", sx(s_data), d);
          exp_done = f; exp_err = e;
        end
        if (s_kind == 2'd1) begin dev[0] = sx(s_data); since = 0; end
        else if (s_kind == 2'd2) begin dev[1] = sx(s_data); since = 0; end
        else if (since < 1000) since++;
      end else if (since < 1000) begin
        since++;
      end
      check(done == exp_done, "R8", "done", int'(done), int'(exp_done));
      if (exp_done) check(err == exp_err, exp_err ? "R9" : "R8", "err", int'(err), int'(exp_err));
      exp_ref = s_start && s_busy && !s_por && s_qempty;
      check(refused == exp_ref, exp_ref ? "R4" : "R4 R12", "refused", int'(refused), int'(exp_ref));
      if (s_req && !s_ack)
        check(wr_req && wr_kind == s_kind && wr_data == s_data, "R2", "held write data",
              sx(wr_data), sx(s_data));
      last_acc = acc;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      mdl_dev[c] = 0; dev[c] = 0;
      for (int h = 0; h < 2; h++) stored[c][h] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    check(wr_req == 1'b0, "R1", "wr_req", int'(wr_req), 0);
    check(done == 1'b0, "R1", "done", int'(done), 0);
    check(err == 1'b0, "R1", "err", int'(err), 0);
    check(refused == 1'b0, "R1", "refused", int'(refused), 0);
    // R1 R10: stored results read back as zero through head reloads
    set_head(1, "R1 R10");
    set_head(0, "R1 R10");
    // R3 R5 R7 R8: rising search on A, then falling search on B with slow acks
    run_cal(0, 3, 0);
    run_cal(1, -2, 2);
    // R5: restart from the last written A code
    run_cal(0, 1, 1);
    // R9: both range ends
    run_cal(0, 40, 0);
    check(err == 1'b1, "R9", "err level after upper limit", int'(err), 1);
    run_cal(1, -40, 0);
    // R4: refused while drive busy
    drive_busy = 1'b1;
    pulse_start(0);
    repeat (6) @(negedge clk);
    check(q_kind.size() == 0 && wr_req == 1'b0, "R4", "no write after refusal", int'(wr_req), 0);
    // R3: allowed during power-on reset condition even with drive busy
    por_active = 1'b1;
    run_cal(1, 5, 1);
    check(err == 1'b0, "R3 R8", "err cleared by new run", int'(err), 0);
    por_active = 1'b0;
    drive_busy = 1'b0;
    // R10: per-head storage
    set_head(1, "R10");
    run_cal(0, -5, 0);
    set_head(0, "R10");
    set_head(1, "R10");
    // R11 R12: head change and a second start during a run
    ack_lat = 1; thr = 2; cal_ch = 1;
    plan_cal(1, 1, 2);
    plan_head(0, "R11");
    pulse_start(1);
    repeat (3) @(negedge clk);
    head_sel = 1'b0;
    cur_head = 0;
    drive_busy = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drive_busy = 1'b0;
    drain();
    set_head(1, "R11");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule